// File: doc/BRIEF.md
# Subtract-and-Branch Processor Core

This core executes a machine with a single operation and no opcode field. Every instruction is three consecutive memory words. The first word is the address of the subtrahend. The second is the address of the minuend. The third is the branch target. The core subtracts the subtrahend value from the minuend value and writes the difference back to the minuend word. It then branches to the target if the signed difference is zero or negative, and otherwise moves on to the next instruction. An operand word holding a negative value is indirect: the address actually used is read from the word that the value's magnitude points to.

Program and data share one internal single-port synchronous memory. While the core is idle or halted, a host port loads and reads that memory. After reset the core waits for a start pulse, then runs from address zero. A cycle-level sequencer drives it and makes one memory access per cycle, so run time depends on how many operands are indirect. A branch taken to the all-ones address stops the core and raises the halt output.

Top module: `sbq_core`

## Requirements
- R1: An instruction at program counter p is the word at p (subtrahend address A), the word at p+1 (minuend address B) and the word at p+2 (target C). All three are read in that order, and no word carries an opcode.
- R2: Each instruction stores mem[B] - mem[A] into mem[B]. Words are 16-bit two's complement and wrap on overflow, so 0x8000 - 1 gives 0x7FFF.
- R3: If the stored difference is zero or negative as a signed value, the program counter takes C. Otherwise it advances by 3.
- R4: An operand word with bit 15 set is indirect. Its magnitude, truncated to 8 bits, addresses a pointer word, and the low 8 bits of that pointer word are the address used. This applies separately to A, B and C.
- R5: An instruction with only direct operands takes 7 clock cycles. Each indirect operand adds exactly 1 cycle.
- R6: A taken branch to address 0xFF raises halt. Halt stays high, and the core writes no further memory, until reset.
- R7: Reset clears the program counter and halt and leaves the core idle, but it does not alter memory. A start pulse sampled while idle begins execution at address 0. Halt rises on the 7th clock edge after the start edge for a one-instruction direct program.
- R8: While the core is idle or halted, hostWe writes hostWdata to hostAddr on a clock edge. hostRdata presents the word at the hostAddr sampled on the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin execution at address 0 when idle |
| halt | output | 1 | High once the core has stopped |
| hostWe | input | 1 | Host memory write strobe (idle or halted only) |
| hostAddr | input | 8 | Host memory address |
| hostWdata | input | 16 | Host write data |
| hostRdata | output | 16 | Memory word read at the previous hostAddr |

## Verification
Halt is due a fixed number of edges after the start edge: 7 per executed direct instruction plus 1 per indirect operand. The bench counts falling edges from the one that follows the start edge and compares the count at which halt is first seen against the figure worked out by hand for each preloaded program. Memory results are checked only after halt. Each read sets the address at a falling edge and samples hostRdata at the next falling edge, one register stage later. Expected words are queued as each program is loaded and are popped by the monitor once the program has stopped.

// File: rtl/sbq_pkg.sv
package sbq_pkg;
  // destination of the word returned by the read issued one cycle earlier
  typedef enum logic [2:0] {TAG_NONE, TAG_A, TAG_B, TAG_C, TAG_VA, TAG_VB} tag_e;
  // memory address source chosen by the sequencer
  typedef enum logic [2:0] {AS_PC0, AS_PC1, AS_PC2, AS_PTRA, AS_PTRB, AS_PTRC, AS_EFFA, AS_EFFB} asel_e;
  typedef enum logic [3:0] {
    ST_IDLE, ST_FA, ST_FB, ST_FC, ST_IA, ST_IB, ST_RA, ST_RB, ST_WR, ST_IC, ST_PCU, ST_HALT
  } state_e;
  typedef struct packed {
    logic  rd;
    logic  we;
    asel_e asel;
    tag_e  tag;
    logic  pcClear;
    logic  pcLoad;
  } strobe_t;
endpackage

// File: rtl/sbq_ram.sv
module sbq_ram #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/sbq_datapath.sv
module sbq_datapath
  import sbq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [ADDR_W-1:0] pc,
  output logic              negA,
  output logic              negB,
  output logic              negC,
  output logic              resLe,
  output logic              tgtHalt
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(3);

  logic [DATA_W-1:0] opA, opB, opC, valA;
  logic [DATA_W-1:0] curA, curB, curC, diff;
  tag_e tagQ;

  function automatic logic [ADDR_W-1:0] magAddr(input logic [DATA_W-1:0] v);
    logic [DATA_W-1:0] m;
    m = v[DATA_W-1] ? (~v + 1'b1) : v;
    return m[ADDR_W-1:0];
  endfunction

  // forward a word that lands this cycle
  always_comb begin
    curA = (tagQ == TAG_A) ? rdata : opA;
    curB = (tagQ == TAG_B) ? rdata : opB;
    curC = (tagQ == TAG_C) ? rdata : opC;
  end

  assign negA    = curA[DATA_W-1];
  assign negB    = curB[DATA_W-1];
  assign negC    = curC[DATA_W-1];
  assign tgtHalt = &curC[ADDR_W-1:0];
  assign diff    = rdata - valA;
  assign memWdata = diff;

  always_comb begin
    case (stb.asel)
      AS_PC0:  memAddr = pc;
      AS_PC1:  memAddr = pc + ADDR_W'(1);
      AS_PC2:  memAddr = pc + ADDR_W'(2);
      AS_PTRA: memAddr = magAddr(curA);
      AS_PTRB: memAddr = magAddr(curB);
      AS_PTRC: memAddr = magAddr(curC);
      AS_EFFA: memAddr = curA[ADDR_W-1:0];
      default: memAddr = curB[ADDR_W-1:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc    <= '0;
      tagQ  <= TAG_NONE;
      resLe <= 1'b0;
    end else begin
      tagQ <= stb.rd ? stb.tag : TAG_NONE;
      case (tagQ)
        TAG_A:   opA  <= rdata;
        TAG_B:   opB  <= rdata;
        TAG_C:   opC  <= rdata;
        TAG_VA:  valA <= rdata;
        default: ;
      endcase
      if (stb.we) resLe <= diff[DATA_W-1] | (diff == '0);
      if (stb.pcClear)     pc <= '0;
      else if (stb.pcLoad) pc <= resLe ? curC[ADDR_W-1:0] : pc + STEP;
    end
  end
endmodule

// File: rtl/sbq_control.sv
module sbq_control
  import sbq_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    start,
  input  logic    negA,
  input  logic    negB,
  input  logic    negC,
  input  logic    resLe,
  input  logic    tgtHalt,
  output strobe_t stb,
  output state_e  state,
  output logic    busy,
  output logic    halt
);
  state_e nextState;

  always_comb begin
    stb       = '{rd: 1'b0, we: 1'b0, asel: AS_PC0, tag: TAG_NONE, pcClear: 1'b0, pcLoad: 1'b0};
    nextState = state;
    case (state)
      ST_IDLE: if (start) begin
        stb.pcClear = 1'b1;
        nextState   = ST_FA;
      end
      ST_FA: begin
        stb.rd = 1'b1; stb.asel = AS_PC0; stb.tag = TAG_A;
        nextState = ST_FB;
      end
      ST_FB: begin
        stb.rd = 1'b1; stb.asel = AS_PC1; stb.tag = TAG_B;
        nextState = ST_FC;
      end
      ST_FC: begin
        stb.rd = 1'b1; stb.asel = AS_PC2; stb.tag = TAG_C;
        nextState = negA ? ST_IA : (negB ? ST_IB : ST_RA);
      end
      ST_IA: begin
        stb.rd = 1'b1; stb.asel = AS_PTRA; stb.tag = TAG_A;
        nextState = negB ? ST_IB : ST_RA;
      end
      ST_IB: begin
        stb.rd = 1'b1; stb.asel = AS_PTRB; stb.tag = TAG_B;
        nextState = ST_RA;
      end
      ST_RA: begin
        stb.rd = 1'b1; stb.asel = AS_EFFA; stb.tag = TAG_VA;
        nextState = ST_RB;
      end
      ST_RB: begin
        stb.rd = 1'b1; stb.asel = AS_EFFB; stb.tag = TAG_VB;
        nextState = ST_WR;
      end
      ST_WR: begin
        stb.we = 1'b1; stb.asel = AS_EFFB;
        nextState = negC ? ST_IC : ST_PCU;
      end
      ST_IC: begin
        stb.rd = 1'b1; stb.asel = AS_PTRC; stb.tag = TAG_C;
        nextState = ST_PCU;
      end
      ST_PCU: begin
        stb.pcLoad = 1'b1;
        nextState  = (resLe && tgtHalt) ? ST_HALT : ST_FA;
      end
      default: nextState = ST_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nextState;
  end

  assign busy = (state != ST_IDLE) && (state != ST_HALT);
  assign halt = (state == ST_HALT);
endmodule

// File: rtl/sbq_core.sv
module sbq_core
  import sbq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              halt,
  input  logic              hostWe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata
);
  strobe_t           stb;
  state_e            ctrlState;
  logic              busy, negA, negB, negC, resLe, tgtHalt;
  logic [ADDR_W-1:0] dpAddr, pc, ramAddr;
  logic [DATA_W-1:0] dpWdata, ramWdata, ramRdata;
  logic              ramWe;

  sbq_control u_ctrl (
    .clk(clk), .rst(rst), .start(start), .negA(negA), .negB(negB), .negC(negC),
    .resLe(resLe), .tgtHalt(tgtHalt), .stb(stb), .state(ctrlState), .busy(busy), .halt(halt)
  );

  sbq_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rst(rst), .stb(stb), .rdata(ramRdata), .memAddr(dpAddr), .memWdata(dpWdata),
    .pc(pc), .negA(negA), .negB(negB), .negC(negC), .resLe(resLe), .tgtHalt(tgtHalt)
  );

  // host owns the port whenever the sequencer is not running
  assign ramAddr  = busy ? dpAddr  : hostAddr;
  assign ramWdata = busy ? dpWdata : hostWdata;
  assign ramWe    = busy ? stb.we  : hostWe;

  sbq_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .clk(clk), .we(ramWe), .addr(ramAddr), .wdata(ramWdata), .rdata(ramRdata)
  );

  assign hostRdata = ramRdata;
endmodule

// File: rtl/sbq_core_chk.sv
module sbq_core_chk
  import sbq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              halt,
  input logic              coreWe,
  input state_e            state,
  input logic [ADDR_W-1:0] pc
);
  a_r6_halt_sticky: assert property (@(posedge clk) disable iff (rst) halt |=> halt);

  a_r6_no_core_write: assert property (@(posedge clk) disable iff (rst)
    $past(halt) |-> !coreWe);

  a_r1_fetch_order: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FB) |-> ($past(state) == ST_FA));

  a_r5_update_after_write: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PCU) |-> ($past(state) == ST_WR || $past(state) == ST_IC));

  a_r7_reset_pc: assert property (@(posedge clk) $past(rst) |-> (pc == '0));

  a_r7_start_at_zero: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FA && $past(state) == ST_IDLE) |-> (pc == '0));
endmodule

bind sbq_core sbq_core_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .halt(halt), .coreWe(stb.we), .state(ctrlState), .pc(pc)
);

// File: tb/sbq_core_tb.sv
module sbq_core_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        halt;
  logic        hostWe = 1'b0;
  logic [7:0]  hostAddr = '0;
  logic [15:0] hostWdata = '0;
  logic [15:0] hostRdata;

  int checks = 0;
  int failures = 0;

  typedef struct {
    logic [7:0]  addr;
    logic [15:0] value;
    string       req;
  } exp_t;
  exp_t expQ[$];

  sbq_core u_dut (
    .clk(clk), .rst(rst), .start(start), .halt(halt), .hostWe(hostWe),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdata(hostRdata)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic poke(input logic [7:0] a, input logic [15:0] v);
    @(negedge clk); hostWe = 1'b1; hostAddr = a; hostWdata = v;
    @(negedge clk); hostWe = 1'b0;
  endtask

  task automatic peek(input logic [7:0] a, output logic [15:0] v);
    @(negedge clk); hostAddr = a;
    @(negedge clk); v = hostRdata;
  endtask

  // driver side: queue an expected memory word
  task automatic expectWord(input logic [7:0] a, input logic [15:0] v, input string req);
    exp_t e;
    e.addr = a; e.value = v; e.req = req;
    expQ.push_back(e);
  endtask

  // monitor side: pop and compare against memory once the core has stopped
  task automatic drainExpected();
    logic [15:0] got;
    while (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      peek(e.addr, got);
      check(e.req, {16'h0, got}, {16'h0, e.value});
    end
  endtask

  task automatic runProgram(input int expCycles, input string req);
    int n;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    n = 0;
    while (!halt && n < 2000) begin
      @(negedge clk);
      n++;
    end
    check(req, n, expCycles);
  endtask

  initial begin : watchdog
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [15:0] rd;
    doReset();
    check("R7 reset halt low", {31'h0, halt}, 32'h0);
    repeat (5) @(negedge clk);
    check("R7 idle without start", {31'h0, halt}, 32'h0);

    // host port write then read (R8)
    poke(8'd200, 16'hBEEF);
    peek(8'd200, rd);
    check("R8 host readback", {16'h0, rd}, 32'hBEEF);

    // program 1: clear a word, then count down to zero (R1 R2 R3 R5 R6)
    poke(0, 12); poke(1, 12); poke(2, 6);
    poke(3, 15); poke(4, 15); poke(5, 255);
    poke(6, 13); poke(7, 14); poke(8, 255);
    poke(9, 15); poke(10, 15); poke(11, 6);
    poke(12, 55); poke(13, 1); poke(14, 3); poke(15, 0);
    expectWord(12, 16'd0, "R2 word cleared");
    expectWord(14, 16'd0, "R3 counter reached zero");
    expectWord(13, 16'd1, "R2 subtrahend unchanged");
    expectWord(0, 16'd12, "R1 program word intact");
    runProgram(42, "R5 R3 direct loop halt cycle");
    check("R6 halt raised", {31'h0, halt}, 32'h1);
    repeat (6) @(negedge clk);
    check("R6 halt held", {31'h0, halt}, 32'h1);
    drainExpected();

    // program 2: indirect A, B and C (R4 R5)
    doReset();
    poke(0, 16'(-20)); poke(1, 16'(-22)); poke(2, 16'(-24));
    poke(3, 25); poke(4, 26); poke(5, 16'(-24));
    poke(20, 21); poke(21, 5); poke(22, 23); poke(23, 12);
    poke(24, 255); poke(25, 9); poke(26, 4);
    expectWord(23, 16'd7, "R4 indirect A and B result");
    expectWord(26, 16'hFFFB, "R2 negative result");
    expectWord(21, 16'd5, "R4 pointed source unchanged");
    expectWord(20, 16'd21, "R4 pointer word unchanged");
    runProgram(18, "R5 indirect timing");
    drainExpected();

    // reset keeps memory, start reruns from address 0 (R7)
    doReset();
    check("R7 halt cleared by reset", {31'h0, halt}, 32'h0);
    peek(23, rd);
    check("R7 memory kept over reset", {16'h0, rd}, 32'd7);
    expectWord(23, 16'd2, "R7 rerun from zero");
    expectWord(26, 16'hFFF2, "R3 rerun taken branch");
    runProgram(18, "R7 rerun cycles");
    drainExpected();

    // program 3: two's complement wrap decides a not-taken branch (R2 R3)
    doReset();
    poke(0, 6); poke(1, 7); poke(2, 255);
    poke(3, 8); poke(4, 8); poke(5, 255);
    poke(6, 1); poke(7, 16'h8000); poke(8, 16'h1234);
    expectWord(7, 16'h7FFF, "R2 wrap result");
    expectWord(8, 16'h0000, "R3 fall through to next");
    runProgram(14, "R3 wrap not taken timing");
    drainExpected();

    // one direct instruction halting at once (R7 timing from start edge)
    doReset();
    poke(0, 30); poke(1, 30); poke(2, 255); poke(30, 16'h0042);
    expectWord(30, 16'h0000, "R3 zero result taken");
    runProgram(7, "R7 single instruction halt edge");
    drainExpected();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule